// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries a stream of data words from one clock domain to a second, unrelated one. The producer side runs on `wr_clk` and the consumer side on `rd_clk`. Each side has its own active-high reset. Storage is a register array of `2**ADDR_W` entries. It is written on the producer clock and read asynchronously at the consumer's current address.

Each side keeps a binary pointer one bit wider than the address. It also keeps a registered copy of that pointer in reflected Gray code. The Gray copy is passed to the other domain through a two-flop synchronizer clocked by the receiving domain. There it is converted back to binary and compared with the local pointer. Because the remote pointer is always old, the status is conservative. A side learns immediately that it has filled or drained the FIFO. It learns about room or data freed by the other side only after the synchronizer delay.

Both data interfaces are valid/ready. A word is accepted on `wr_clk` when `wr_valid` and `wr_ready` are both high; `wr_ready` low means the FIFO is full. A word is consumed on `rd_clk` when `rd_valid` and `rd_ready` are both high; `rd_data` is meaningful only while `rd_valid` is high. The valid signals may be held high against a low ready without effect. The coarse flags `wr_almost_full` and `rd_almost_empty` come from comparing pointer quadrants, taken from the top three Gray bits.

Top module: `gray_cdc_fifo`

## Requirements
- R1: The FIFO holds exactly 2**ADDR_W words. Each side's Gray pointer changes in at most one bit per clock and follows the reflected sequence 0,1,3,2,6,7,5,4,... over 2**(ADDR_W+1) values.
- R2: Words leave on `rd_data` in the order they were accepted, with no loss or duplication.
- R3: After both resets, `wr_ready`=1, `wr_almost_full`=0, `rd_valid`=0 and `rd_almost_empty`=1.
- R4: A write presented while `wr_ready`=0 is ignored: nothing is stored and the words read out afterwards are unchanged.
- R5: A read presented while `rd_valid`=0 is ignored: the read pointer does not move and the next word written is the next word read.
- R6: `wr_ready` drops in the first `wr_clk` cycle after the edge that accepts the 2**ADDR_W-th stored word, and not earlier.
- R7: `rd_valid` drops in the first `rd_clk` cycle after the edge that consumes the last stored word, and not earlier.
- R8: A write into an empty FIFO raises `rd_valid` after the second `rd_clk` edge that follows the write edge, not after the first. A read from a full FIFO raises `wr_ready` after the second following `wr_clk` edge, not after the first.
- R9: Let q(p) be pointer bits [ADDR_W:ADDR_W-2] and d = (q(write) - q(read)) mod 8. With the other side's pointer settled, `wr_almost_full` = (d >= 3).
- R10: With the same d and the write pointer settled in the read domain, `rd_almost_empty` = (d <= 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer-side reset, active high |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word (not full) |
| wr_data | input | DATA_W | Word to store |
| wr_almost_full | output | 1 | Quadrant-based high-fill indication |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer-side reset, active high |
| rd_valid | output | 1 | A word is available (not empty) |
| rd_ready | input | 1 | Consumer takes the word this cycle |
| rd_data | output | DATA_W | Word at the head of the FIFO |
| rd_almost_empty | output | 1 | Quadrant-based low-fill indication |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=4: 16 entries, 32 pointer values and 4-entry quadrants. It runs every fill level from 0 to 16 and drains after each one, so the pointers wrap several times. Every quadrant difference is therefore reached at every pointer phase. The clock periods, 10 ns and 13 ns, are offset so that edges never coincide. This makes the two-edge release latency exact and checkable in both directions.

// File: rtl/gcf_pkg.sv
package gcf_pkg;
  // Quadrant index (binary) from the three most significant Gray bits.
  function automatic logic [2:0] quad_of(input logic [2:0] g);
    logic [2:0] b;
    b[2] = g[2];
    b[1] = g[2] ^ g[1];
    b[0] = g[2] ^ g[1] ^ g[0];
    return b;
  endfunction

  // Quadrant distance from the trailing pointer to the leading pointer, modulo 8.
  function automatic logic [2:0] quad_gap(input logic [2:0] lead_g, input logic [2:0] trail_g);
    return quad_of(lead_g) - quad_of(trail_g);
  endfunction
endpackage

// File: rtl/gcf_sync.sv
module gcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gcf_mem.sv
module gcf_mem #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wen,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (wen) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/gcf_wr_ctl.sv
module gcf_wr_ctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        valid,
  output logic        ready,
  output logic        almost_full,
  input  logic [AW:0] rgray_far,
  output logic [AW:0] wgray,
  output logic [AW-1:0] waddr,
  output logic        wen
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wbin_nx, rgray_s, rbin_s;
  logic          full, push;

  gcf_sync #(.W(PW)) u_rsync (.clk(clk), .rst(rst), .d(rgray_far), .q(rgray_s));

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
  end

  assign full    = (wbin[AW-1:0] == rbin_s[AW-1:0]) && (wbin[AW] != rbin_s[AW]);
  assign ready   = !full;
  assign push    = valid && ready;
  assign wbin_nx = wbin + PW'(push);
  assign waddr   = wbin[AW-1:0];
  assign wen     = push;

  assign almost_full = gcf_pkg::quad_gap(wgray[PW-1:PW-3], rgray_s[PW-1:PW-3]) >= 3'd3;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // R4: a refused write leaves the pointer where it was
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (wbin == $past(wbin)));
  // R1: the exported Gray pointer changes at most one bit per clock
  a_r1_wgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);
  // R9: a full FIFO always reports almost full
  a_r9_full_afull: assert property (@(posedge clk) disable iff (rst)
    !ready |-> almost_full);
endmodule

// File: rtl/gcf_rd_ctl.sv
module gcf_rd_ctl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst,
  output logic        valid,
  input  logic        ready,
  output logic        almost_empty,
  input  logic [AW:0] wgray_far,
  output logic [AW:0] rgray,
  output logic [AW-1:0] raddr
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, wgray_s, wbin_s;
  logic          empty, pop;

  gcf_sync #(.W(PW)) u_wsync (.clk(clk), .rst(rst), .d(wgray_far), .q(wgray_s));

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
  end

  assign empty   = (rbin == wbin_s);
  assign valid   = !empty;
  assign pop     = valid && ready;
  assign rbin_nx = rbin + PW'(pop);
  assign raddr   = rbin[AW-1:0];

  assign almost_empty = gcf_pkg::quad_gap(wgray_s[PW-1:PW-3], rgray[PW-1:PW-3]) <= 3'd1;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  // R5: a read while empty leaves the pointer where it was
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (ready && !valid) |=> (rbin == $past(rbin)));
  // R1: the exported Gray pointer changes at most one bit per clock
  a_r1_rgray_step: assert property (@(posedge clk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
  // R10: an empty FIFO always reports almost empty
  a_r10_empty_aempty: assert property (@(posedge clk) disable iff (rst)
    !valid |-> almost_empty);
endmodule

// File: rtl/gray_cdc_fifo.sv
module gray_cdc_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4   // at least 2, so that quadrants exist
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_almost_full,
  input  logic              rd_clk,
  input  logic              rd_rst,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_almost_empty
);
  logic [ADDR_W:0]   wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wen;

  gcf_wr_ctl #(.AW(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .valid(wr_valid), .ready(wr_ready),
    .almost_full(wr_almost_full), .rgray_far(rgray), .wgray(wgray),
    .waddr(waddr), .wen(wen)
  );

  gcf_rd_ctl #(.AW(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .valid(rd_valid), .ready(rd_ready),
    .almost_empty(rd_almost_empty), .wgray_far(wgray), .rgray(rgray),
    .raddr(raddr)
  );

  gcf_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .wen(wen), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/tb_gray_cdc_fifo.sv
`timescale 1ns/100ps
module tb_gray_cdc_fifo;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PMOD = 2 * DEPTH;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, wr_almost_full, rd_valid, rd_almost_empty;
  logic [DW-1:0] rd_data;

  int checks = 0, failures = 0;
  int wptr_m = 0, rptr_m = 0, seq = 0;
  logic [DW-1:0] mdata [DEPTH];

  always #5 wr_clk = ~wr_clk;
  initial begin
    #0.3;
    forever #6.5 rd_clk = ~rd_clk;
  end

  gray_cdc_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_almost_full(wr_almost_full),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_almost_empty(rd_almost_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int occ();
    return (wptr_m - rptr_m + PMOD) % PMOD;
  endfunction

  function automatic int qgap();
    return (((wptr_m >> (AW - 2)) & 7) - ((rptr_m >> (AW - 2)) & 7) + 8) % 8;
  endfunction

  // Offer one word; the model follows the handshake seen before the edge.
  task automatic push(output bit took);
    logic [DW-1:0] v;
    v = DW'(seq * 37 + 5);
    wr_data = v;
    wr_valid = 1;
    took = wr_ready;
    @(posedge wr_clk); #1;
    wr_valid = 0;
    if (took) begin
      mdata[wptr_m % DEPTH] = v;
      wptr_m = (wptr_m + 1) % PMOD;
      seq++;
    end
  endtask

  task automatic pop(input string req);
    chk({req, " rd_valid before read"}, 32'(rd_valid), 32'd1);
    chk({req, " data order"}, 32'(rd_data), 32'(mdata[rptr_m % DEPTH]));
    rd_ready = 1;
    @(posedge rd_clk); #1;
    rd_ready = 0;
    rptr_m = (rptr_m + 1) % PMOD;
  endtask

  task automatic settle();
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit took;
    int n_acc;
    repeat (3) @(posedge wr_clk);
    #1;
    wr_rst = 0;
    rd_rst = 0;
    settle();
    // R3 reset state
    chk("R3 wr_ready", 32'(wr_ready), 32'd1);
    chk("R3 wr_almost_full", 32'(wr_almost_full), 32'd0);
    chk("R3 rd_valid", 32'(rd_valid), 32'd0);
    chk("R3 rd_almost_empty", 32'(rd_almost_empty), 32'd1);

    // Sweep of every fill level; pointers wrap several times.
    for (int rep = 0; rep < 3; rep++) begin
      for (int n = 0; n <= DEPTH; n++) begin
        for (int k = 0; k < n; k++) begin
          push(took);
          chk("R6 wr_ready while filling", 32'(wr_ready), 32'(occ() != DEPTH));
        end
        settle();
        chk("R9 almost full quadrant gap", 32'(wr_almost_full), 32'(qgap() >= 3));
        chk("R10 almost empty quadrant gap", 32'(rd_almost_empty), 32'(qgap() <= 1));
        chk("R6 wr_ready settled", 32'(wr_ready), 32'(occ() != DEPTH));
        chk("R7 rd_valid settled", 32'(rd_valid), 32'(occ() != 0));
        for (int k = 0; k < n; k++) begin
          pop("R2");
          chk("R7 rd_valid while draining", 32'(rd_valid), 32'(occ() != 0));
        end
        settle();
      end
    end

    // R1 capacity: 20 offers into an empty FIFO, only DEPTH accepted
    n_acc = 0;
    for (int k = 0; k < DEPTH + 4; k++) begin
      push(took);
      if (took) n_acc++;
    end
    chk("R1 capacity", 32'(n_acc), 32'(DEPTH));

    // R4: writes offered while full are ignored
    wr_data = 8'hEE;
    wr_valid = 1;
    repeat (5) @(posedge wr_clk);
    #1;
    wr_valid = 0;
    chk("R4 wr_ready stays low", 32'(wr_ready), 32'd0);
    settle();

    // R8: read from full; wr_ready needs two write-clock edges
    pop("R8");
    @(posedge wr_clk); #1;
    chk("R8 wr_ready after 1st wr edge", 32'(wr_ready), 32'd0);
    @(posedge wr_clk); #1;
    chk("R8 wr_ready after 2nd wr edge", 32'(wr_ready), 32'd1);
    settle();
    for (int k = 0; k < DEPTH - 1; k++) pop("R4");
    chk("R4 nothing extra stored", 32'(rd_valid), 32'd0);
    settle();

    // R5: reads offered while empty are ignored
    rd_ready = 1;
    repeat (5) @(posedge rd_clk);
    #1;
    rd_ready = 0;
    chk("R5 rd_valid stays low", 32'(rd_valid), 32'd0);
    chk("R5 almost empty stays high", 32'(rd_almost_empty), 32'd1);

    // R8: write into empty; rd_valid needs two read-clock edges
    push(took);
    chk("R8 write accepted", 32'(took), 32'd1);
    @(posedge rd_clk); #1;
    chk("R8 rd_valid after 1st rd edge", 32'(rd_valid), 32'd0);
    @(posedge rd_clk); #1;
    chk("R8 rd_valid after 2nd rd edge", 32'(rd_valid), 32'd1);
    pop("R5");
    chk("R7 empty after last read", 32'(rd_valid), 32'd0);
    settle();
    chk("R3 idle flags again", 32'(wr_ready), 32'd1);

    summary();
    $finish;
  end
endmodule